// File: doc/BRIEF.md
# Interrupt-Entry Cache Synchronizer

This block stands between the interrupt request line of a core and a small write-back data cache. When an interrupt is taken, it brings the cache's memory traffic to a settled state. Only then does it tell the core that it may fetch the handler vector. A two-word posted write buffer drains to memory through a write port that uses a request and acknowledge handshake. Loads reach memory through a read port with the same handshake. A load that does not allocate reads one word. A load that allocates first waits for the write buffer to empty and then reloads a whole block, one word at a time.

An allocating load is committed once it has been accepted. Its block reload always runs to the end, even if the interrupt arrives while the buffer is still draining. When an interrupt is pending, the block that was reloaded is not put into the cache. Instead, the install port returns the victim line from the copy-back buffer. When the synchronizer has settled, it raises `vec_ready` and holds a saturating count of the cycles it spent synchronizing. The core then hands over the handler address. The block spends one cycle routing it to the program counter and one more cycle driving it onto the fetch address outputs.

Top module: `irq_cache_quiesce`

## Requirements
- R1: The write buffer accepts `wb_wdata` when `wb_push` and `wb_ready` are both high. It holds at most two words and writes them out on `mw_data` in arrival order. `mw_req` and `mw_data` stay steady until `mw_ack` arrives.
- R2: `irq_req` starts synchronization when synchronization is not in progress and `vec_ready` is low. `vec_ready` rises only once the write buffer is empty and no load activity remains (`ld_busy` low).
- R3: A non-allocating load (`ld_alloc` = 0) issues exactly one read and finishes on its acknowledge, even when an interrupt arrives while it is pending.
- R4: An allocating load (`ld_alloc` = 1) drops `wb_ready` and keeps `mr_req` low until the write buffer is empty.
- R5: After an allocating load has been accepted, it performs all BLK_WORDS reads, even if the interrupt arrives during its flush wait or its reload.
- R6: After the last reload word, `inst_valid` pulses for one cycle. `inst_victim` = 0 means the reloaded block is installed. `inst_victim` = 1 means the victim line is returned and the reloaded data is dropped. The value is 1 exactly when synchronization is in progress.
- R7: `ld_req` and `wb_push` are ignored during synchronization and while `vec_ready` is high. A further `irq_req` is ignored in both cases as well. When `irq_req` and `ld_req` arrive in the same cycle, the interrupt is taken and the load is ignored.
- R8: `sync_cycles` clears when synchronization starts. It then counts every cycle that synchronization is in progress, including the cycle in which `vec_ready` rises, and saturates at 255. It holds its value until the next synchronization starts.
- R9: `hv_valid` while `vec_ready` is high acknowledges the vector. `vec_ready` falls on the next cycle. `fetch_valid` pulses with `fetch_addr` = `hv_addr` two cycles after the accepting edge.
- R10: After reset, the buffer is empty, no load is active, and `wb_ready` is high. `vec_ready`, `fetch_valid` and `sync_cycles` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 1 | Interrupt request |
| wb_push | input | 1 | Store word offered to the write buffer |
| wb_wdata | input | DW | Store word |
| wb_ready | output | 1 | Write buffer will accept a word |
| mw_req | output | 1 | Memory write request |
| mw_data | output | DW | Word being written |
| mw_ack | input | 1 | Memory write complete |
| ld_req | input | 1 | Load request |
| ld_alloc | input | 1 | Load allocates a cache block |
| ld_busy | output | 1 | Load or reload activity pending |
| mr_req | output | 1 | Memory read request |
| mr_ack | input | 1 | Memory read word delivered |
| inst_valid | output | 1 | Cache line install pulse |
| inst_victim | output | 1 | Install carries the victim line, not the reloaded one |
| vec_ready | output | 1 | Safe to fetch the handler vector |
| hv_valid | input | 1 | Handler address valid |
| hv_addr | input | AW | Handler address |
| fetch_valid | output | 1 | Fetch address valid |
| fetch_addr | output | AW | Fetch address |
| sync_cycles | output | CW | Cycles spent in the last synchronization |

## Verification
The bench builds the block with 16-bit words, a 12-bit address, a four-word block and an 8-bit counter. Its memory responders take their latencies from variables that change during the run. With a write latency of 3 and a read latency of 2, interrupts can be made to land in the flush wait, in mid-reload and in a single-word read. Raising the write latency to 300 cycles drives the counter past 255, so its saturation can be checked.

// File: rtl/irq_cache_quiesce.sv
module irq_cache_quiesce #(
  parameter int DW = 16,
  parameter int AW = 16,
  parameter int BLK_WORDS = 4,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq_req,
  input  logic          wb_push,
  input  logic [DW-1:0] wb_wdata,
  output logic          wb_ready,
  output logic          mw_req,
  output logic [DW-1:0] mw_data,
  input  logic          mw_ack,
  input  logic          ld_req,
  input  logic          ld_alloc,
  output logic          ld_busy,
  output logic          mr_req,
  input  logic          mr_ack,
  output logic          inst_valid,
  output logic          inst_victim,
  output logic          vec_ready,
  input  logic          hv_valid,
  input  logic [AW-1:0] hv_addr,
  output logic          fetch_valid,
  output logic [AW-1:0] fetch_addr,
  output logic [CW-1:0] sync_cycles
);
  localparam int BW = $clog2(BLK_WORDS + 1);

  typedef enum logic [2:0] {L_IDLE, L_WORD, L_FLUSH, L_RELOAD, L_INST} ld_t;

  ld_t           lst;
  logic [DW-1:0] wb_mem [2];
  logic          wb_head;
  logic [1:0]    wb_cnt;
  logic [BW-1:0] left;
  logic          syncing;
  logic          p1v;
  logic [AW-1:0] p1a;

  wire wb_take  = wb_push && wb_ready;
  wire wb_pop   = (wb_cnt != 2'd0) && mw_ack;
  wire irq_take = irq_req && !syncing && !vec_ready;
  wire ld_take  = ld_req && lst == L_IDLE && !syncing && !vec_ready && !irq_req;
  wire done     = syncing && wb_cnt == 2'd0 && lst == L_IDLE;
  wire hv_take  = vec_ready && hv_valid;

  assign wb_ready    = wb_cnt != 2'd2 && !syncing && !vec_ready && lst != L_FLUSH;
  assign mw_req      = wb_cnt != 2'd0;
  assign mw_data     = wb_mem[wb_head];
  assign ld_busy     = lst != L_IDLE;
  assign mr_req      = lst == L_WORD || lst == L_RELOAD;
  assign inst_valid  = lst == L_INST;
  assign inst_victim = inst_valid && syncing;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_head <= 1'b0;
      wb_cnt  <= 2'd0;
    end else begin
      if (wb_take) wb_mem[wb_head ^ wb_cnt[0]] <= wb_wdata;
      if (wb_pop) wb_head <= ~wb_head;
      wb_cnt <= wb_cnt + {1'b0, wb_take} - {1'b0, wb_pop};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lst  <= L_IDLE;
      left <= '0;
    end else begin
      unique case (lst)
        L_IDLE: if (ld_take) begin
          lst  <= ld_alloc ? L_FLUSH : L_WORD;
          left <= BW'(BLK_WORDS);
        end
        L_WORD:  if (mr_ack) lst <= L_IDLE;
        L_FLUSH: if (wb_cnt == 2'd0) lst <= L_RELOAD;
        L_RELOAD: if (mr_ack) begin
          left <= left - 1'b1;
          if (left == BW'(1)) lst <= L_INST;
        end
        L_INST:  lst <= L_IDLE;
        default: lst <= L_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      syncing     <= 1'b0;
      vec_ready   <= 1'b0;
      sync_cycles <= '0;
      p1v         <= 1'b0;
      p1a         <= '0;
      fetch_valid <= 1'b0;
      fetch_addr  <= '0;
    end else begin
      if (irq_take) begin
        syncing     <= 1'b1;
        sync_cycles <= '0;
      end else if (syncing) begin
        sync_cycles <= sync_cycles + CW'(sync_cycles != '1);
        if (done) begin
          syncing   <= 1'b0;
          vec_ready <= 1'b1;
        end
      end
      if (hv_take) vec_ready <= 1'b0;
      p1v <= hv_take;
      if (hv_take) p1a <= hv_addr;
      fetch_valid <= p1v;
      if (p1v) fetch_addr <= p1a;
    end
  end
endmodule

// File: rtl/irq_cache_quiesce_chk.sv
module irq_cache_quiesce_chk #(
  parameter int DW = 16,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mw_req,
  input logic          mw_ack,
  input logic [DW-1:0] mw_data,
  input logic          ld_busy,
  input logic          mr_req,
  input logic          inst_valid,
  input logic          vec_ready,
  input logic          hv_valid,
  input logic          fetch_valid,
  input logic [CW-1:0] sync_cycles
);
  assert_write_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mw_req && !mw_ack |=> mw_req && $stable(mw_data));

  assert_ready_when_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_ready) |-> !mw_req && !ld_busy);

  assert_install_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    inst_valid |=> !inst_valid);

  assert_install_no_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    inst_valid |-> !mr_req);

  assert_ready_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_ready && !hv_valid |=> vec_ready);

  assert_count_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_ready && $past(vec_ready) |-> $stable(sync_cycles));

  assert_ack_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vec_ready && hv_valid |=> !vec_ready ##1 fetch_valid);
endmodule

bind irq_cache_quiesce irq_cache_quiesce_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mw_req(mw_req), .mw_ack(mw_ack), .mw_data(mw_data),
  .ld_busy(ld_busy), .mr_req(mr_req), .inst_valid(inst_valid),
  .vec_ready(vec_ready), .hv_valid(hv_valid), .fetch_valid(fetch_valid),
  .sync_cycles(sync_cycles)
);

// File: tb/irq_cache_quiesce_tb.sv
module irq_cache_quiesce_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16, AW = 12, BLK = 4, CW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic irq_req = 0, wb_push = 0, mw_ack = 0, ld_req = 0, ld_alloc = 0, mr_ack = 0, hv_valid = 0;
  logic [DW-1:0] wb_wdata = '0;
  logic [AW-1:0] hv_addr = '0;
  logic wb_ready, mw_req, ld_busy, mr_req, inst_valid, inst_victim, vec_ready, fetch_valid;
  logic [DW-1:0] mw_data;
  logic [AW-1:0] fetch_addr;
  logic [CW-1:0] sync_cycles;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_cache_quiesce #(.DW(DW), .AW(AW), .BLK_WORDS(BLK), .CW(CW)) u_dut (.*);

  int checks = 0, fails = 0, cyc = 0;
  int wr_lat = 3, rd_lat = 2, wcnt = 0, rcnt = 0, rd_acks = 0, victims = 0, normals = 0;

  // reference model state
  logic [DW-1:0] q[$];
  int ph = 0, left = 0, m_cnt = 0;
  bit sy = 0, vr = 0, p1v = 0, fv = 0;
  logic [AW-1:0] p1a = '0, fa = '0;

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); ph = 0; left = 0; m_cnt = 0; sy = 0; vr = 0; p1v = 0; fv = 0;
    end else begin
      int qs; bit rdy, take_irq, take_ld, fin, old_sy;
      qs = q.size();
      old_sy = sy;
      rdy = qs < 2 && !sy && !vr && ph != 2;
      take_irq = irq_req && !sy && !vr;
      take_ld = ld_req && ph == 0 && !sy && !vr && !irq_req;
      fin = sy && qs == 0 && ph == 0;
      if (qs > 0 && mw_ack) void'(q.pop_front());
      if (wb_push && rdy) q.push_back(wb_wdata);
      if (ph == 4) begin if (old_sy) victims++; else normals++; end
      case (ph)
        0: if (take_ld) begin ph = ld_alloc ? 2 : 1; left = BLK; end
        1: if (mr_ack) ph = 0;
        2: if (qs == 0) ph = 3;
        3: if (mr_ack) begin left--; if (left == 0) ph = 4; end
        default: ph = 0;
      endcase
      fv = p1v;
      if (p1v) fa = p1a;
      p1v = vr && hv_valid;
      if (p1v) p1a = hv_addr;
      if (vr && hv_valid) vr = 0;
      if (take_irq) begin sy = 1; m_cnt = 0; end
      else if (sy) begin
        if (m_cnt < 255) m_cnt++;
        if (fin) begin sy = 0; vr = 1; end
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk("R1 wb_ready", wb_ready, q.size() < 2 && !sy && !vr && ph != 2);
      chk("R1 mw_req", mw_req, q.size() > 0);
      if (q.size() > 0) chk("R1 mw_data", mw_data, q[0]);
      chk("R4 mr_req", mr_req, ph == 1 || ph == 3);
      chk("R3 ld_busy", ld_busy, ph != 0);
      chk("R6 inst_valid", inst_valid, ph == 4);
      if (ph == 4) chk("R6 inst_victim", inst_victim, sy);
      chk("R2 vec_ready", vec_ready, vr);
      chk("R8 sync_cycles", sync_cycles, m_cnt);
      chk("R9 fetch_valid", fetch_valid, fv);
      if (fv) chk("R9 fetch_addr", fetch_addr, fa);
    end
    if (mw_req) begin wcnt++; mw_ack = (wcnt >= wr_lat); if (mw_ack) wcnt = 0; end
    else begin mw_ack = 0; wcnt = 0; end
    if (mr_req) begin rcnt++; mr_ack = (rcnt >= rd_lat); if (mr_ack) begin rcnt = 0; rd_acks++; end end
    else begin mr_ack = 0; rcnt = 0; end
    if (cyc > 50000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic tick(int n); repeat (n) @(negedge clk); endtask
  task automatic push(logic [DW-1:0] d);
    wb_push = 1; wb_wdata = d; tick(1); wb_push = 0;
  endtask
  task automatic load(bit alloc);
    ld_req = 1; ld_alloc = alloc; tick(1); ld_req = 0;
  endtask
  task automatic irq();
    irq_req = 1; tick(1); irq_req = 0;
  endtask
  task automatic wait_ready();
    for (int i = 0; i < 2000 && !vec_ready; i++) tick(1);
  endtask
  task automatic wait_idle();
    for (int i = 0; i < 2000 && (ld_busy || mw_req); i++) tick(1);
  endtask
  task automatic vector(logic [AW-1:0] a);
    hv_valid = 1; hv_addr = a; tick(1); hv_valid = 0;
    chk("R9 vec_ready drops", vec_ready, 0);
    tick(1);
    chk("R9 fetch pulse", fetch_valid, 1);
    chk("R9 fetch addr", fetch_addr, a);
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    // R10 reset state
    chk("R10 wb_ready", wb_ready, 1);
    chk("R10 vec_ready", vec_ready, 0);
    chk("R10 ld_busy", ld_busy, 0);
    chk("R10 sync_cycles", sync_cycles, 0);
    chk("R10 fetch_valid", fetch_valid, 0);
    chk("R10 mw_req", mw_req, 0);

    // R1: buffered writes drain in order
    push(16'h1111); push(16'h2222); push(16'h3333);
    wait_idle();

    // R4 R6: allocating load, no interrupt, normal install
    push(16'hA001); push(16'hA002);
    rd_acks = 0; normals = 0;
    load(1);
    chk("R4 no read during flush", mr_req, 0);
    wait_idle(); tick(1);
    chk("R5 reload words", rd_acks, BLK);
    chk("R6 normal install", normals, 1);

    // R2 R8: interrupt when idle finishes in one cycle
    irq(); wait_ready();
    chk("R8 idle sync count", sync_cycles, 1);
    vector(12'h100);

    // R3: interrupt during a single-word load
    rd_lat = 5; rd_acks = 0;
    load(0); irq(); wait_ready();
    chk("R3 single read", rd_acks, 1);
    vector(12'h204);
    rd_lat = 2;

    // R5 R6: interrupt during flush wait of allocating load
    push(16'hB001); push(16'hB002);
    rd_acks = 0; victims = 0;
    load(1); irq(); wait_ready();
    chk("R5 reload after irq in flush", rd_acks, BLK);
    chk("R6 victim returned", victims, 1);
    vector(12'h310);

    // R5 R6: interrupt mid-reload
    rd_acks = 0; victims = 0;
    load(1);
    for (int i = 0; i < 50 && !mr_req; i++) tick(1);
    tick(3); irq(); wait_ready();
    chk("R5 reload mid irq", rd_acks, BLK);
    chk("R6 victim mid reload", victims, 1);
    vector(12'h42C);

    // R7: requests ignored during sync and while ready
    wr_lat = 20;
    push(16'hC001); irq();
    load(1); push(16'hC0DE); irq();
    chk("R7 load ignored in sync", ld_busy, 0);
    wait_ready();
    chk("R7 push ignored", mw_req, 0);
    irq_req = 1; tick(3); irq_req = 0;
    load(0);
    chk("R7 ready held", vec_ready, 1);
    chk("R7 load ignored while ready", ld_busy, 0);
    vector(12'h500);
    wr_lat = 3;

    // R7: interrupt beats a load in the same cycle
    irq_req = 1; ld_req = 1; ld_alloc = 0; tick(1); irq_req = 0; ld_req = 0;
    chk("R7 irq priority", ld_busy, 0);
    wait_ready(); vector(12'h600);

    // R8: saturation
    wr_lat = 300;
    push(16'hD00D); irq(); wait_ready();
    chk("R8 saturates", sync_cycles, 255);
    tick(2);
    chk("R8 holds", sync_cycles, 255);
    vector(12'h7F0);
    wr_lat = 3;
    tick(5);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule